// File: doc/BRIEF.md
# Debug Register Frame Engine

This block sits between a byte-level serial receiver/transmitter and a small debug register file. It consumes received bytes, each marked by a one-cycle valid strobe, and turns them into register reads and writes. Every transaction opens with a command byte. Its top bit says whether the host writes or reads. The next bit says whether the target register is one byte or two bytes wide. The six low bits name the register. Write data is gathered and committed in one step. Read data is captured when the command is decoded and sent back one byte at a time over a ready/valid handshake.

After reset the link counts as unsynchronized. The engine ignores traffic until the host sends the reserved synchronization byte 0x80. From then on, 0x80 is decoded as an ordinary command: a two-byte write to register 0. The register file holds twenty-four 16-bit slots. The first two are fixed identification words. The rest are plain storage.

Top module: `dbgreg_frame_engine`

## Requirements
- R1: After an asynchronous reset the engine waits for a command byte, holds tx_valid_o low, holds all writable registers at zero, and is unsynchronized.
- R2: While unsynchronized, every received byte other than 0x80 is discarded with no response. Receiving 0x80 synchronizes the link and produces no response.
- R3: Once synchronized, command bit 7 selects the direction (1 = write, 0 = read) and command bits 5:0 select the register index. Indices 0x00 to 0x17 exist.
- R4: When command bit 6 is 0, a write takes two data bytes, low byte first. When bit 6 is 1, a write takes one data byte, which lands in bits 7:0 and clears bits 15:8.
- R5: A read returns bits 7:0 first. It returns bits 15:8 as a second byte only when command bit 6 is 0. A narrow read sends exactly one byte.
- R6: A two-byte write changes the register only in the cycle its final data byte arrives. The high and low halves become visible together.
- R7: A read captures the whole register when the command byte is taken. tx_data_o and tx_valid_o hold steady while tx_ready_i is low.
- R8: Registers 0x00 and 0x01 always read 16'h4D31 and 16'h0A17. Writes to them are ignored, but their data bytes are still consumed.
- R9: A write to an index above 0x17 changes no register. A read of such an index returns zero bytes.
- R10: Bytes received while a read response is pending are ignored.
- R11: After each complete transaction the engine returns to waiting for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | One-cycle strobe marking rx_data_i valid |
| tx_data_o | output | 8 | Byte to transmit |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts tx_data_o this cycle |

## Verification
The bench first sends a read command before synchronization. A design that decoded it would start answering at once. The 0x80 byte is then sent both before and after synchronization, which exposes a design that treats it the same way in both link states. Narrow reads are followed by a check for a stray second byte, and narrow writes are checked for a stale high byte. Reads are stalled with tx_ready_i low while new bytes arrive. A design that re-sampled the register or decoded those bytes would send changed data or lose framing on the next transaction. Writes to the identification words and to indices above 0x17 are read back to catch writes that leak through or alias onto another register.

// File: rtl/dbgf_pkg.sv
package dbgf_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 6;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI
  } fsm_state_e;

  typedef struct packed {
    logic             wr;
    logic             narrow;
    logic [IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/dbgf_cmd_decode.sv
module dbgf_cmd_decode
  import dbgf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h80
) (
  input  logic [BYTE_W-1:0] byte_i,
  output cmd_t              cmd_o,
  output logic              is_sync_o
);
  always_comb begin
    cmd_o.wr     = byte_i[7];
    cmd_o.narrow = byte_i[6];
    cmd_o.idx    = byte_i[IDX_W-1:0];
    is_sync_o    = (byte_i == SYNC_BYTE);
  end
endmodule

// File: rtl/dbgf_reg_store.sv
module dbgf_reg_store #(
  parameter int NUM_REGS = 24,
  parameter int NUM_ID   = 2,
  parameter int DATA_W   = 16,
  parameter int AW       = 6,
  parameter logic [NUM_ID*DATA_W-1:0] ID_WORDS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IW = $clog2(NUM_REGS);

  logic [DATA_W-1:0] word [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g < NUM_ID) begin : g_id
      assign word[g] = ID_WORDS[g*DATA_W +: DATA_W];
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  q <= '0;
        else if (wr_en_i && (wr_idx_i == AW'(g)))     q <= wr_data_i;
      end
      assign word[g] = q;
    end
  end

  always_comb begin
    if (rd_idx_i < AW'(NUM_REGS)) rd_data_o = word[rd_idx_i[IW-1:0]];
    else                          rd_data_o = '0;
  end
endmodule

// File: rtl/dbgf_frame_fsm.sv
module dbgf_frame_fsm
  import dbgf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  cmd_t              cmd_i,
  input  logic              is_sync_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              tx_ready_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              synced_o,
  output fsm_state_e        state_o
);
  fsm_state_e        state_q, state_d;
  logic              synced_q;
  logic              narrow_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] lo_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CMD: if (rx_valid_i && synced_q) state_d = cmd_i.wr ? ST_WLO : ST_RLO;
      ST_WLO: if (rx_valid_i) state_d = narrow_q ? ST_CMD : ST_WHI;
      ST_WHI: if (rx_valid_i) state_d = ST_CMD;
      ST_RLO: if (tx_ready_i) state_d = narrow_q ? ST_CMD : ST_RHI;
      ST_RHI: if (tx_ready_i) state_d = ST_CMD;
      default: state_d = ST_CMD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      synced_q <= 1'b0;
      narrow_q <= 1'b0;
      idx_q    <= '0;
      lo_q     <= '0;
      rd_q     <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CMD && rx_valid_i) begin
        if (!synced_q) begin
          if (is_sync_i) synced_q <= 1'b1;
        end else begin
          narrow_q <= cmd_i.narrow;
          idx_q    <= cmd_i.idx;
          // capture full word now so both response bytes agree
          if (!cmd_i.wr) rd_q <= rd_word_i;
        end
      end
      if (state_q == ST_WLO && rx_valid_i) lo_q <= rx_data_i;
    end
  end

  assign rd_idx_o   = cmd_i.idx;
  assign wr_idx_o   = idx_q;
  assign wr_en_o    = rx_valid_i && ((state_q == ST_WLO && narrow_q) || state_q == ST_WHI);
  assign wr_data_o  = (state_q == ST_WHI) ? {rx_data_i, lo_q}
                                          : {{(DATA_W-BYTE_W){1'b0}}, rx_data_i};
  assign tx_valid_o = (state_q == ST_RLO) || (state_q == ST_RHI);
  assign tx_data_o  = (state_q == ST_RHI) ? rd_q[DATA_W-1 -: BYTE_W] : rd_q[BYTE_W-1:0];
  assign synced_o   = synced_q;
  assign state_o    = state_q;
endmodule

// File: rtl/dbgreg_frame_engine.sv
module dbgreg_frame_engine
  import dbgf_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int NUM_ID   = 2,
  parameter int DATA_W   = 16,
  parameter logic [NUM_ID*DATA_W-1:0] ID_WORDS = {16'h0A17, 16'h4D31},
  parameter logic [7:0] SYNC_BYTE = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_ready_i
);
  cmd_t              cmd_w;
  logic              sync_hit_w;
  logic [IDX_W-1:0]  rd_idx_w;
  logic [IDX_W-1:0]  wr_idx_w;
  logic              wr_en_w;
  logic [DATA_W-1:0] wr_data_w;
  logic [DATA_W-1:0] rd_word_w;
  logic              synced_w;
  fsm_state_e        state_w;

  dbgf_cmd_decode #(.SYNC_BYTE(SYNC_BYTE)) u_dec (
    .byte_i    (rx_data_i),
    .cmd_o     (cmd_w),
    .is_sync_o (sync_hit_w)
  );

  dbgf_reg_store #(
    .NUM_REGS (NUM_REGS),
    .NUM_ID   (NUM_ID),
    .DATA_W   (DATA_W),
    .AW       (IDX_W),
    .ID_WORDS (ID_WORDS)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_w),
    .wr_idx_i  (wr_idx_w),
    .wr_data_i (wr_data_w),
    .rd_idx_i  (rd_idx_w),
    .rd_data_o (rd_word_w)
  );

  dbgf_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .cmd_i      (cmd_w),
    .is_sync_i  (sync_hit_w),
    .rd_word_i  (rd_word_w),
    .tx_ready_i (tx_ready_i),
    .rd_idx_o   (rd_idx_w),
    .wr_en_o    (wr_en_w),
    .wr_idx_o   (wr_idx_w),
    .wr_data_o  (wr_data_w),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .synced_o   (synced_w),
    .state_o    (state_w)
  );
endmodule

// File: rtl/dbgf_engine_chk.sv
module dbgf_engine_chk
  import dbgf_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_valid_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       tx_ready_i,
  input logic       synced_i,
  input logic       wr_en_i,
  input fsm_state_e state_i
);
  // R7
  hold_tx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R2
  unsync_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !synced_i |-> !tx_valid_o);

  // R6
  commit_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> rx_valid_i);

  // R11
  idle_after_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (state_i == ST_CMD));

  // R10
  resp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RLO && !tx_ready_i) |=> (state_i == ST_RLO));

  // R2
  sync_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    synced_i |=> synced_i);
endmodule

bind dbgreg_frame_engine dbgf_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .tx_data_o  (tx_data_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .synced_i   (synced_w),
  .wr_en_i    (wr_en_w),
  .state_i    (state_w)
);

// File: tb/dbgreg_frame_engine_tb.sv
module dbgreg_frame_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dbgreg_frame_engine dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rx_data_i  (rx_data),
    .rx_valid_i (rx_valid),
    .tx_data_o  (tx_data),
    .tx_valid_o (tx_valid),
    .tx_ready_i (tx_ready)
  );

  // {is_write, 7'b0, cmd, data-or-expected}
  localparam int NV = 16;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 7'd0, 8'h85, 16'hBEEF},
    {1'b0, 7'd0, 8'h05, 16'hBEEF},
    {1'b1, 7'd0, 8'hC2, 16'h005A},
    {1'b0, 7'd0, 8'h42, 16'h005A},
    {1'b0, 7'd0, 8'h00, 16'h4D31},  // R8
    {1'b0, 7'd0, 8'h01, 16'h0A17},  // R8
    {1'b1, 7'd0, 8'h80, 16'h1234},  // R8 write to ID
    {1'b0, 7'd0, 8'h00, 16'h4D31},
    {1'b1, 7'd0, 8'h81, 16'h5678},
    {1'b0, 7'd0, 8'h01, 16'h0A17},
    {1'b1, 7'd0, 8'h97, 16'hA5C3},
    {1'b0, 7'd0, 8'h17, 16'hA5C3},
    {1'b1, 7'd0, 8'h98, 16'h1111},  // R9 out of range
    {1'b0, 7'd0, 8'h18, 16'h0000},  // R9
    {1'b1, 7'd0, 8'hC5, 16'h0077},  // R4 narrow clears high
    {1'b0, 7'd0, 8'h05, 16'h0077}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data  = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    int t = 0;
    while (!tx_valid && t < 50) begin
      @(negedge clk);
      t++;
    end
    b = tx_valid ? tx_data : 8'hXX;
    if (!tx_valid) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 actual=no byte expected=byte");
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] cmd, output logic [15:0] w);
    logic [7:0] b0, b1;
    send(cmd);
    recv(b0);
    w = {8'h00, b0};
    if (!cmd[6]) begin
      recv(b1);
      w[15:8] = b1;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    // R1
    check(tx_valid == 1'b0, "R1 tx idle in reset", {15'd0, tx_valid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid == 1'b0, "R1 tx idle after reset", {15'd0, tx_valid}, 16'h0000);

    // R2: read command before sync ignored
    send(8'h00);
    repeat (4) begin
      check(tx_valid == 1'b0, "R2 unsynced read ignored", {15'd0, tx_valid}, 16'h0000);
      @(negedge clk);
    end
    send(8'h80);
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0, "R2 sync byte silent", {15'd0, tx_valid}, 16'h0000);
    rd(8'h00, w);
    check(w == 16'h4D31, "R2 R3 first read after sync", w, 16'h4D31);

    // R1: writable register resets to zero
    rd(8'h0A, w);
    check(w == 16'h0000, "R1 writable reset value", w, 16'h0000);

    // table
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      if (v[31]) begin
        send(v[23:16]);
        send(v[7:0]);
        if (!v[22]) send(v[15:8]);
      end else begin
        rd(v[23:16], w);
        check(w == v[15:0], "R3 R4 R5 R8 R9 table read", w, v[15:0]);
      end
    end

    // R5: narrow read emits exactly one byte
    send(8'h42);
    recv(b);
    check(tx_valid == 1'b0, "R5 narrow single byte", {15'd0, tx_valid}, 16'h0000);

    // R6: two-byte write lands whole
    send(8'h86);
    send(8'h11);
    repeat (3) @(negedge clk);
    send(8'h22);
    rd(8'h06, w);
    check(w == 16'h2211, "R6 full write committed", w, 16'h2211);

    // R7 R10: stall response, push bytes meanwhile
    tx_ready = 1'b0;
    send(8'h17);
    send(8'hD7);
    send(8'h99);
    repeat (3) @(negedge clk);
    check(tx_valid && tx_data == 8'hC3, "R7 held low byte", {8'h00, tx_data}, 16'h00C3);
    tx_ready = 1'b1;
    recv(b);
    check(b == 8'hC3, "R7 low byte", {8'h00, b}, 16'h00C3);
    recv(b);
    check(b == 8'hA5, "R7 high byte", {8'h00, b}, 16'h00A5);
    // R11 framing intact, R10 no write from ignored bytes
    rd(8'h17, w);
    check(w == 16'hA5C3, "R10 R11 register unchanged", w, 16'hA5C3);

    // R11 + R1: reset mid-write returns to unsynced idle
    send(8'h85);
    send(8'h33);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(8'h05);
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0, "R1 R11 unsynced after reset", {15'd0, tx_valid}, 16'h0000);
    send(8'h80);
    rd(8'h05, w);
    check(w == 16'h0000, "R1 reset cleared register", w, 16'h0000);

    finish_run();
  end
endmodule